// File: doc/BRIEF.md
# Floating-Point Register Specifier Decoder

This block sits in the issue path of a floating-point unit. It takes the three 5-bit register fields of a floating-point instruction and an operand size code for each, and turns them into physical indices into a register file of 64 entries, each 32 bits wide. Double and quad operands use an encoding where the lowest field bit selects the upper half of the file. A quad specifier that is not aligned is reported as a bad register.

The block holds the recorded floating-point trap-type field. Before it decodes, it checks that field against the operation class that the requester expects, unless the request came in through an illegal-instruction path. It also keeps one "written" flag for each half of the register file. A source operand in a half that has never been written must read as zero. The first write into such a half must clear the whole half before the result lands. The block signals both events and leaves the data movement to the register file.

All results are registered and appear one cycle after the request.

Top module: `fp_regspec_decoder`

## Requirements
- R1: The destination field is instruction bits 29:25, the first source bits 18:14 and the second source bits 4:0. For size code 1 (single) the physical index is the 5-bit field, zero-extended to 6 bits.
- R2: For size code 2 (double) and 3 (quad) the physical index is {field[0], field[4:1], 1'b0}. Index bit 5 is the field's bit 0.
- R3: When the request passes the class check and any quad operand has field bit 1 set, the result is out_accept=0 and out_fault=2. trap_type becomes 6, and neither the written flags nor the write and clear outputs change.
- R4: When req_illegal_path is 0 and trap_type differs from req_class, the request is rejected with out_accept=0 and out_fault=1. trap_type keeps its value and no flags change. This check takes priority over R3.
- R5: A request with req_illegal_path=1 skips the class check. On a request that passes, trap_type is cleared to 0 unless R3 sets it to 6.
- R6: On an accepted request, out_rs1_zero and out_rs2_zero are 1 for a used source whose half (index bit 5: 0 lower, 1 upper) has its written flag clear. The flags used are the ones from before this request.
- R7: On an accepted request with a used destination, out_rd_write is 1. If that half's flag was clear, out_clear_lo or out_clear_hi pulses and the flag is set. Later writes to that half give no pulse.
- R8: Size code 0 (none) gives index 0 and no zero flag. For the destination it gives no write.
- R9: The outputs change at the first rising clock edge after a request with req_valid=1. out_valid is 1 for exactly that one cycle. Zero, write and clear outputs are 0 outside accepted results.
- R10: After reset, trap_type is 0, both written flags are 0 and all outputs are 0.
- R11: When no request is presented, trap_set=1 loads trap_value into trap_type at the next edge. A request in the same cycle wins.
- R12: half_written shows the written flags, with bit 0 for the lower half and bit 1 for the upper half. A flag only ever clears through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Decode request |
| req_instr | input | 32 | Instruction word holding the three register fields |
| req_rd_size | input | 2 | Destination size code (0 none, 1 single, 2 double, 3 quad) |
| req_rs1_size | input | 2 | First source size code |
| req_rs2_size | input | 2 | Second source size code |
| req_class | input | 3 | Trap type the operation expects |
| req_illegal_path | input | 1 | Request came through an illegal-instruction path; skip the class check |
| trap_set | input | 1 | Load a trap type recorded by the execution unit |
| trap_value | input | 3 | Trap type to load |
| out_valid | output | 1 | Result valid, one cycle after a request |
| out_accept | output | 1 | Request decoded without fault |
| out_fault | output | 2 | 0 none, 1 class mismatch, 2 bad register |
| out_rd_idx | output | 6 | Destination physical index |
| out_rs1_idx | output | 6 | First source physical index |
| out_rs2_idx | output | 6 | Second source physical index |
| out_rs1_zero | output | 1 | First source reads as zero |
| out_rs2_zero | output | 1 | Second source reads as zero |
| out_rd_write | output | 1 | Destination will be written |
| out_clear_lo | output | 1 | Clear lower half before the write |
| out_clear_hi | output | 1 | Clear upper half before the write |
| trap_type | output | 3 | Current trap-type field |
| half_written | output | 2 | Written flags, bit 0 lower, bit 1 upper |

## Verification
The bench targets several corner cases, each with a distinct failure it would expose.

- **Odd double and quad fields.** A mapper that simply shifts the field would place these in the wrong half.
- **Quad fields with bit 1 set.** A decoder that checks only one operand, or that still updates the written flags, would leave a misaligned request partly committed.
- **Rejection on a trap-type mismatch, next to the illegal-path bypass.** A design that cleared the field before comparing, or that ignored the bypass, would corrupt or refuse legal requests.
- **First and repeated writes to each half, with sources in a clean half read in the same request.** A design that consulted the updated flag would miss the read-as-zero case, and one that re-pulsed the clear would wipe live data.

// File: rtl/fp_regspec_pkg.sv
// Package: shared types for the FP register specifier decoder.
// Assumes size codes and fault codes are fixed 2-bit encodings.
package fp_regspec_pkg;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_SGL  = 2'd1,
        SZ_DBL  = 2'd2,
        SZ_QUAD = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_CLASS  = 2'd1,
        FLT_BADREG = 2'd2
    } fault_e;

endpackage

// File: rtl/fp_spec_map.sv
// Module: fp_spec_map
// Maps one register field and its size code to a physical index.
// Assumes IDX_W = FIELD_W + 1 (two halves of 2**FIELD_W entries).
// Purely combinational.
module fp_spec_map
    import fp_regspec_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int IDX_W   = FIELD_W + 1
) (
    input  logic [FIELD_W-1:0] field,
    input  opsize_e            size,
    output logic [IDX_W-1:0]   idx,
    output logic               used,
    output logic               misaligned
);

    // Size-dependent index formation and quad alignment check.
    always_comb begin
        idx        = '0;
        used       = (size != SZ_NONE);
        misaligned = 1'b0;
        unique case (size)
            SZ_NONE: idx = '0;
            SZ_SGL:  idx = {1'b0, field};
            SZ_DBL:  idx = {field[0], field[FIELD_W-1:1], 1'b0};
            SZ_QUAD: begin
                idx        = {field[0], field[FIELD_W-1:1], 1'b0};
                misaligned = field[1];
            end
            default: idx = '0;
        endcase
    end

endmodule

// File: rtl/fp_half_track.sv
// Module: fp_half_track
// Keeps a written flag for each half of the register file.
// Reports read-as-zero for sources and a clear request on the first destination write.
// Assumes the half is selected by the top index bit. Flags clear only on reset.
module fp_half_track #(
    parameter int IDX_W   = 6,
    parameter int N_HALF  = 2,
    parameter int N_SRC   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [N_SRC-1:0][IDX_W-1:0] src_idx,
    input  logic [N_SRC-1:0]            src_used,
    input  logic [IDX_W-1:0]            dst_idx,
    input  logic                        dst_used,
    output logic [N_SRC-1:0]            src_zero,
    output logic [N_HALF-1:0]           clr_half,
    output logic [N_HALF-1:0]           written
);

    localparam int HSEL_W = (N_HALF > 1) ? $clog2(N_HALF) : 1;

    logic [HSEL_W-1:0] dst_half;
    assign dst_half = HSEL_W'(dst_idx[IDX_W-1]);

    genvar s, h;
    generate
        for (s = 0; s < N_SRC; s++) begin : g_src
            // Source reads zero when its half has never been written.
            always_comb begin
                src_zero[s] = commit && src_used[s]
                              && !written[HSEL_W'(src_idx[s][IDX_W-1])];
            end
        end
        for (h = 0; h < N_HALF; h++) begin : g_half
            // Clear request for this half on its first write.
            always_comb begin
                clr_half[h] = commit && dst_used && (dst_half == HSEL_W'(h)) && !written[h];
            end
            // Written flag for this half: set on the first write, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    written[h] <= 1'b0;
                else if (clr_half[h])
                    written[h] <= 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/fp_class_gate.sv
// Module: fp_class_gate
// Holds the trap-type field and checks it against the operation's class.
// Assumes a request has priority over a concurrent trap load.
module fp_class_gate #(
    parameter int          FTT_W   = 3,
    parameter logic [2:0]  BAD_REG = 3'd6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [FTT_W-1:0] cls,
    input  logic             bypass,
    input  logic             any_bad,
    input  logic             load,
    input  logic [FTT_W-1:0] load_val,
    output logic             pass,
    output logic [FTT_W-1:0] ftt
);

    // Class match, unless the request is on the illegal-instruction path.
    assign pass = bypass || (ftt == cls);

    // Trap-type register: kept on reject, set on bad register, else cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ftt <= '0;
        else if (req) begin
            if (pass)
                ftt <= any_bad ? FTT_W'(BAD_REG) : '0;
        end else if (load)
            ftt <= load_val;
    end

endmodule

// File: rtl/fp_regspec_decoder.sv
// Module: fp_regspec_decoder (top)
// Decodes the three FP register fields of an instruction into physical indices,
// checks quad alignment and trap class, and tracks written halves.
// Assumes a 64 x 32-bit register file split into two halves. Results are registered.
module fp_regspec_decoder
    import fp_regspec_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int INSN_W  = 32,
    parameter int RD_LSB  = 25,
    parameter int RS1_LSB = 14,
    parameter int RS2_LSB = 0,
    parameter int FTT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_instr,
    input  logic [1:0]        req_rd_size,
    input  logic [1:0]        req_rs1_size,
    input  logic [1:0]        req_rs2_size,
    input  logic [2:0]        req_class,
    input  logic              req_illegal_path,
    input  logic              trap_set,
    input  logic [2:0]        trap_value,
    output logic              out_valid,
    output logic              out_accept,
    output logic [1:0]        out_fault,
    output logic [5:0]        out_rd_idx,
    output logic [5:0]        out_rs1_idx,
    output logic [5:0]        out_rs2_idx,
    output logic              out_rs1_zero,
    output logic              out_rs2_zero,
    output logic              out_rd_write,
    output logic              out_clear_lo,
    output logic              out_clear_hi,
    output logic [2:0]        trap_type,
    output logic [1:0]        half_written
);

    localparam int IDX_W  = FIELD_W + 1;
    localparam int N_OPS  = 3;
    localparam int OP_RS1 = 0;
    localparam int OP_RS2 = 1;
    localparam int OP_RD  = 2;

    logic [N_OPS-1:0][FIELD_W-1:0] fields;
    opsize_e [N_OPS-1:0]           sizes;
    logic [N_OPS-1:0][IDX_W-1:0]   idx;
    logic [N_OPS-1:0]              used;
    logic [N_OPS-1:0]              misal;
    logic                          unused_insn_bits;

    // Field extraction from the instruction word.
    always_comb begin
        fields[OP_RS1] = req_instr[RS1_LSB +: FIELD_W];
        fields[OP_RS2] = req_instr[RS2_LSB +: FIELD_W];
        fields[OP_RD]  = req_instr[RD_LSB  +: FIELD_W];
        sizes[OP_RS1]  = opsize_e'(req_rs1_size);
        sizes[OP_RS2]  = opsize_e'(req_rs2_size);
        sizes[OP_RD]   = opsize_e'(req_rd_size);
    end
    assign unused_insn_bits = ^{req_instr[INSN_W-1:RD_LSB+FIELD_W],
                                req_instr[RD_LSB-1:RS1_LSB+FIELD_W],
                                req_instr[RS1_LSB-1:RS2_LSB+FIELD_W]};

    genvar g;
    generate
        for (g = 0; g < N_OPS; g++) begin : g_map
            fp_spec_map #(.FIELD_W(FIELD_W), .IDX_W(IDX_W)) map_i (
                .field      (fields[g]),
                .size       (sizes[g]),
                .idx        (idx[g]),
                .used       (used[g]),
                .misaligned (misal[g])
            );
        end
    endgenerate

    logic any_bad, pass, commit;
    assign any_bad = |misal;

    fp_class_gate #(.FTT_W(FTT_W), .BAD_REG(3'd6)) gate_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_valid),
        .cls      (req_class),
        .bypass   (req_illegal_path),
        .any_bad  (any_bad),
        .load     (trap_set),
        .load_val (trap_value),
        .pass     (pass),
        .ftt      (trap_type)
    );

    assign commit = req_valid && pass && !any_bad;

    logic [1:0] src_zero;
    logic [1:0] clr_half;

    fp_half_track #(.IDX_W(IDX_W), .N_HALF(2), .N_SRC(2)) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .src_idx  ({idx[OP_RS2], idx[OP_RS1]}),
        .src_used ({used[OP_RS2], used[OP_RS1]}),
        .dst_idx  (idx[OP_RD]),
        .dst_used (used[OP_RD]),
        .src_zero (src_zero),
        .clr_half (clr_half),
        .written  (half_written)
    );

    fault_e fault_d;

    // Fault classification: class mismatch outranks bad register.
    always_comb begin
        if (!pass)
            fault_d = FLT_CLASS;
        else if (any_bad)
            fault_d = FLT_BADREG;
        else
            fault_d = FLT_NONE;
    end

    // Output register stage: results appear one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            out_valid    <= 1'b0;
            out_accept   <= 1'b0;
            out_fault    <= 2'd0;
            out_rd_idx   <= '0;
            out_rs1_idx  <= '0;
            out_rs2_idx  <= '0;
            out_rs1_zero <= 1'b0;
            out_rs2_zero <= 1'b0;
            out_rd_write <= 1'b0;
            out_clear_lo <= 1'b0;
            out_clear_hi <= 1'b0;
        end else begin
            out_valid    <= 1'b1;
            out_accept   <= commit;
            out_fault    <= fault_d;
            out_rd_idx   <= idx[OP_RD];
            out_rs1_idx  <= idx[OP_RS1];
            out_rs2_idx  <= idx[OP_RS2];
            out_rs1_zero <= src_zero[0];
            out_rs2_zero <= src_zero[1];
            out_rd_write <= commit && used[OP_RD];
            out_clear_lo <= clr_half[0];
            out_clear_hi <= clr_half[1];
        end
    end

endmodule

// File: rtl/fp_regspec_checker.sv
// Module: fp_regspec_checker
// Assertions on the decoder's ports, attached through bind.
module fp_regspec_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_rd_size,
    input logic       out_valid,
    input logic       out_accept,
    input logic [1:0] out_fault,
    input logic [5:0] out_rd_idx,
    input logic       out_rs1_zero,
    input logic       out_rs2_zero,
    input logic       out_rd_write,
    input logic       out_clear_lo,
    input logic       out_clear_hi,
    input logic [2:0] trap_type,
    input logic [1:0] half_written
);

    p_badreg_sets_ftt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault == 2'd2) |-> (trap_type == 3'd6 && !out_accept));

    p_reject_keeps_ftt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fault == 2'd1) |-> (trap_type == $past(trap_type) && $stable(half_written)));

    p_accept_clears_ftt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_accept) |-> (trap_type == 3'd0 && out_fault == 2'd0));

    p_pair_index_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(req_rd_size) >= 2'd2) |-> (out_rd_idx[0] == 1'b0));

    p_clear_lo_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_clear_lo |-> (!$past(half_written[0]) && half_written[0] && out_rd_write));

    p_clear_hi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_clear_hi |-> (!$past(half_written[1]) && half_written[1] && out_rd_write));

    p_flags_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(half_written[0]) && !$fell(half_written[1]));

    p_side_outputs_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_accept |-> !(out_rs1_zero || out_rs2_zero || out_rd_write || out_clear_lo || out_clear_hi));

    p_one_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_clear_lo, out_clear_hi}));

endmodule

bind fp_regspec_decoder fp_regspec_checker chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_rd_size  (req_rd_size),
    .out_valid    (out_valid),
    .out_accept   (out_accept),
    .out_fault    (out_fault),
    .out_rd_idx   (out_rd_idx),
    .out_rs1_zero (out_rs1_zero),
    .out_rs2_zero (out_rs2_zero),
    .out_rd_write (out_rd_write),
    .out_clear_lo (out_clear_lo),
    .out_clear_hi (out_clear_hi),
    .trap_type    (trap_type),
    .half_written (half_written)
);

// File: tb/fp_regspec_decoder_tb.sv
// Bench: random and directed requests checked against a reference model.
module fp_regspec_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_instr = '0;
    logic [1:0]  req_rd_size = '0, req_rs1_size = '0, req_rs2_size = '0;
    logic [2:0]  req_class = '0;
    logic        req_illegal_path = 1'b0;
    logic        trap_set = 1'b0;
    logic [2:0]  trap_value = '0;
    logic        out_valid, out_accept, out_rs1_zero, out_rs2_zero;
    logic        out_rd_write, out_clear_lo, out_clear_hi;
    logic [1:0]  out_fault, half_written;
    logic [5:0]  out_rd_idx, out_rs1_idx, out_rs2_idx;
    logic [2:0]  trap_type;

    int n_checks = 0;
    int n_errors = 0;
    logic [2:0] m_ftt = '0;
    logic [1:0] m_flags = '0;

    always #2 clk = ~clk;

    fp_regspec_decoder dut_i (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_idx(input logic [4:0] f, input logic [1:0] sz);
        if (sz == 2'd0) return 6'd0;
        if (sz == 2'd1) return {1'b0, f};
        return {f[0], f[4:1], 1'b0};
    endfunction

    task automatic load_trap(input logic [2:0] v);
        @(negedge clk);
        trap_set = 1'b1; trap_value = v;
        @(negedge clk);
        trap_set = 1'b0;
        m_ftt = v;
        check(trap_type == v, "R11", "trap load", 32'(trap_type), 32'(v));
    endtask

    task automatic do_req(input logic [31:0] insn, input logic [1:0] szd,
                          input logic [1:0] sz1, input logic [1:0] sz2,
                          input logic [2:0] cls, input logic ill);
        logic [4:0] fd, f1, f2;
        logic [5:0] id, i1, i2;
        logic pass, bad, acc;
        logic [1:0] flt;
        logic [2:0] nftt;
        logic z1, z2, wr, clo, chi;
        fd = insn[29:25]; f1 = insn[18:14]; f2 = insn[4:0];
        id = ref_idx(fd, szd); i1 = ref_idx(f1, sz1); i2 = ref_idx(f2, sz2);
        pass = ill || (m_ftt == cls);
        bad  = (szd == 2'd3 && fd[1]) || (sz1 == 2'd3 && f1[1]) || (sz2 == 2'd3 && f2[1]);
        acc  = pass && !bad;
        flt  = !pass ? 2'd1 : (bad ? 2'd2 : 2'd0);
        nftt = !pass ? m_ftt : (bad ? 3'd6 : 3'd0);
        z1   = acc && sz1 != 0 && !m_flags[i1[5]];
        z2   = acc && sz2 != 0 && !m_flags[i2[5]];
        wr   = acc && szd != 0;
        clo  = wr && !id[5] && !m_flags[0];
        chi  = wr &&  id[5] && !m_flags[1];
        @(negedge clk);
        req_valid = 1'b1; req_instr = insn; req_rd_size = szd;
        req_rs1_size = sz1; req_rs2_size = sz2; req_class = cls; req_illegal_path = ill;
        @(negedge clk);
        req_valid = 1'b0;
        m_ftt = nftt;
        if (clo) m_flags[0] = 1'b1;
        if (chi) m_flags[1] = 1'b1;
        check(out_valid == 1'b1, "R9", "valid", 32'(out_valid), 1);
        check(out_rd_idx == id, szd >= 2 ? "R2" : "R1", "rd idx", 32'(out_rd_idx), 32'(id));
        check(out_rs1_idx == i1, sz1 >= 2 ? "R2" : "R1", "rs1 idx", 32'(out_rs1_idx), 32'(i1));
        check(out_rs2_idx == i2, sz2 == 0 ? "R8" : "R1", "rs2 idx", 32'(out_rs2_idx), 32'(i2));
        check(out_fault == flt && out_accept == acc, flt == 1 ? "R4" : "R3", "fault/accept",
              32'({out_fault, out_accept}), 32'({flt, acc}));
        check(trap_type == nftt, "R5", "trap type", 32'(trap_type), 32'(nftt));
        check(out_rs1_zero == z1 && out_rs2_zero == z2, "R6", "zero flags",
              32'({out_rs1_zero, out_rs2_zero}), 32'({z1, z2}));
        check(out_rd_write == wr && out_clear_lo == clo && out_clear_hi == chi, "R7",
              "write/clear", 32'({out_rd_write, out_clear_lo, out_clear_hi}), 32'({wr, clo, chi}));
        check(half_written == m_flags, "R12", "written flags", 32'(half_written), 32'(m_flags));
        @(negedge clk);
        check(out_valid == 1'b0 && out_rd_write == 1'b0, "R9", "one-cycle valid",
              32'({out_valid, out_rd_write}), 0);
    endtask

    function automatic logic [31:0] mk(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
        return {2'b10, d, 6'b110100, a, 9'h041, b};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(trap_type == 0 && half_written == 0 && out_valid == 0 && out_fault == 0,
              "R10", "reset state", 32'({trap_type, half_written, out_valid}), 0);

        // R4: class mismatch rejected, trap type kept
        load_trap(3'd2);
        do_req(mk(5'd4, 5'd1, 5'd2), 2'd3, 2'd3, 2'd3, 3'd3, 1'b0);
        // R5: illegal path bypass clears trap type; R6 sources in clean halves
        do_req(mk(5'd4, 5'd1, 5'd8), 2'd1, 2'd2, 2'd1, 3'd3, 1'b1);
        // R3: misaligned quad destination
        load_trap(3'd3);
        do_req(mk(5'd6, 5'd0, 5'd4), 2'd3, 2'd3, 2'd3, 3'd3, 1'b0);
        // R3: misaligned quad on second source only
        load_trap(3'd3);
        do_req(mk(5'd0, 5'd4, 5'd3), 2'd3, 2'd3, 2'd3, 3'd3, 1'b0);
        // R2/R7: odd double field lands in upper half, first-write clear
        load_trap(3'd2);
        do_req(mk(5'd5, 5'd7, 5'd0), 2'd2, 2'd2, 2'd0, 3'd2, 1'b0);
        // R7: second write to upper half gives no clear; R8 none source
        load_trap(3'd2);
        do_req(mk(5'd9, 5'd0, 5'd0), 2'd2, 2'd0, 2'd0, 3'd2, 1'b0);
        // R8: comparison-style request with no destination
        load_trap(3'd3);
        do_req(mk(5'd31, 5'd8, 5'd12), 2'd0, 2'd3, 2'd3, 3'd3, 1'b0);

        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [2:0] cls;
            logic [31:0] insn;
            cls = ($urandom % 2) ? 3'd3 : 3'd2;
            insn = $urandom;
            if (($urandom % 5) != 0) load_trap(cls);
            else load_trap(3'($urandom));
            do_req(insn, 2'($urandom), 2'($urandom), 2'($urandom), cls, ($urandom % 6) == 0);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule